// File: doc/BRIEF.md
# Register-Mapped Byte Serial Master

This block is a serial peripheral interface master that a host drives through four 32-bit registers. The host can read the state of the current byte operation and can set up the frame format. It drives one slave-select line and a tri-state control for the data output. Each byte operation is one of two kinds. A transmit operation shifts the data register out on the serial output. A receive operation shifts eight bits in and stores them in the low byte of the data register. The two never run together as a full-duplex exchange.

The host writes the configuration register and the data byte first. It then writes a start command to the control register and polls the busy flag until the operation is over. The serial clock runs only while an operation is in progress. Its rate is the system clock divided by a power of two, chosen by a 3-bit code, and the top code turns the clock off. Bit order, clock idle level and the launch and sample edges are fixed for the whole byte when the operation is accepted.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the configuration register reads 0x0000_0153 (MSB-first, idle-high clock, transmit launched on the falling edge, receive sampled on the rising edge, divider code 3). The control register reads 0x0000_0009, status reads 0, data reads 0, `spi_cs_n` is 1, `spi_mosi_oe` is 0 and `spi_sclk` is 1.
- R2: The registers sit at byte offsets 0x00 (status, bit 0 = busy), 0x10 (configuration), 0x14 (control) and 0x20 (data, bits [7:0]). Unused bits read 0. The start bits, control bits 2 and 1, always read back as 0.
- R3: With divider code n in 0..6, busy reads 1 for exactly 16·2^n system cycles, starting in the cycle after the start write. `spi_sclk` toggles every 2^n cycles during that time, so the clock period is 2^(n+1) cycles.
- R4: Writing control bit 2 as 1 transmits the data byte on `spi_mosi`. The first bit is present before the first clock edge. Configuration bit 8 = 1 sends bit 7 first and 0 sends bit 0 first. New bits are launched on the falling clock edge when configuration bit 4 is 1, and on the rising edge when it is 0.
- R5: Writing control bit 1 as 1 (with bit 2 clear) receives eight bits from `spi_miso`. Bits are sampled on the falling edge when configuration bit 5 is 1, and on the rising edge when it is 0. Configuration bit 8 gives the order as in R4. The byte lands in data bits [7:0] on the same clock edge that busy falls.
- R6: While no operation runs, `spi_sclk` equals configuration bit 6 from the previous cycle.
- R7: One cycle after a control write, `spi_cs_n` equals control bit 0 (0 selects the slave) and `spi_mosi_oe` equals the inverse of control bit 3.
- R8: A start command written while busy is 1 is ignored. The running byte finishes unchanged and no further operation follows.
- R9: A start command while the divider code is 7 is ignored. Busy stays 0 and `spi_sclk` does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Slave select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | Output enable for `spi_mosi` (0 = high impedance) |
| spi_miso | input | 1 | Serial data in |

## Verification
Busy appears in the first sample after the start write and stays up for 16·2^n samples. The bench counts falling-edge samples of the status bit from that first sample, so the count equals the requirement exactly. A serial clock toggle is produced on a rising system edge and is seen by the slave model at the following falling edge. The model then captures `spi_mosi` or advances `spi_miso` from there, and a captured byte is compared with the head of the scoreboard queue. Received bytes and the select and enable pins are read one falling edge after the write or the end of busy, which is when their registers have settled.

// File: rtl/spi_bm_pkg.sv
// Package: shared offsets, bit positions, reset values and the
// configuration record used by the byte serial master.
package spi_bm_pkg;

    localparam int BUS_W   = 32;
    localparam int BYTE_W  = 8;
    localparam int PRESC_W = 3;

    // Register byte offsets
    localparam logic [7:0] OFS_STAT = 8'h00;
    localparam logic [7:0] OFS_CFG  = 8'h10;
    localparam logic [7:0] OFS_CTL  = 8'h14;
    localparam logic [7:0] OFS_DATA = 8'h20;

    // Configuration bit positions
    localparam int CFG_ORDER = 8;
    localparam int CFG_CPOL  = 6;
    localparam int CFG_RXF   = 5;
    localparam int CFG_TXF   = 4;

    // Control bit positions
    localparam int CTL_HIZ  = 3;
    localparam int CTL_GOWR = 2;
    localparam int CTL_GORD = 1;
    localparam int CTL_CSN  = 0;

    localparam logic [PRESC_W-1:0] PRESC_OFF = '1;

    typedef struct packed {
        logic               msb_first;
        logic               cpol;
        logic               rx_fall;
        logic               tx_fall;
        logic [PRESC_W-1:0] presc;
    } spi_cfg_t;

    localparam spi_cfg_t CFG_RESET = '{
        msb_first: 1'b1, cpol: 1'b1, rx_fall: 1'b0, tx_fall: 1'b1,
        presc: PRESC_W'(3)
    };

endpackage

// File: rtl/spi_bm_clkdiv.sv
// Module: half-period timer for the serial clock.
// Emits a one-cycle tick every 2^presc system cycles while run is high.
// Assumes presc never holds the disabled code while run is high.
module spi_bm_clkdiv
    import spi_bm_pkg::*;
#(
    parameter int PW = PRESC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] presc,
    output logic          tick
);
    localparam int MAX_CODE = (1 << PW) - 2;
    localparam int CNT_W    = MAX_CODE + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    // Terminal count of one half period
    always_comb begin
        half_m1 = (CNT_W'(1) << presc) - CNT_W'(1);
        tick    = run && (cnt == half_m1);
    end

    // Count system cycles inside a half period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_bm_engine.sv
// Module: byte shift engine.
// Accepts a transmit or receive command when idle and the clock is on,
// freezes the frame format, drives the serial clock and shifts one byte.
// Assumes start_tx/start_rx are single-cycle command pulses.
module spi_bm_engine
    import spi_bm_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  spi_cfg_t      cfg_live,
    input  logic          start_tx,
    input  logic          start_rx,
    input  logic [BW-1:0] tx_byte,
    input  logic          miso_i,
    output logic          busy,
    output logic          sclk_o,
    output logic          mosi_o,
    output logic          rx_done,
    output logic [BW-1:0] rx_byte
);
    localparam int TOG_N = 2 * BW;
    localparam int TOG_W = $clog2(TOG_N);
    localparam logic [TOG_W-1:0] TOG_LAST = TOG_W'(TOG_N - 1);

    spi_cfg_t         snap;
    logic             is_rx;
    logic [TOG_W-1:0] tcnt;
    logic [BW-1:0]    tx_sh;
    logic [BW-1:0]    rx_sh;
    logic [BW-1:0]    rx_next;
    logic             mosi_q;
    logic             sclk_q;
    logic             tick;
    logic             new_lvl;
    logic             edge_fall;
    logic             launch_ev;
    logic             sample_ev;
    logic             accept;
    logic             last;

    spi_bm_clkdiv #(.PW(PRESC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .presc (snap.presc),
        .tick  (tick)
    );

    // Classify the edge produced by the current tick
    always_comb begin
        new_lvl   = snap.cpol ^ ~tcnt[0];
        edge_fall = ~new_lvl;
        launch_ev = tick && (edge_fall == snap.tx_fall);
        sample_ev = tick && (edge_fall == snap.rx_fall);
        accept    = (start_tx || start_rx) && !busy && (cfg_live.presc != PRESC_OFF);
        last      = tick && (tcnt == TOG_LAST);
        rx_next   = snap.msb_first ? {rx_sh[BW-2:0], miso_i} : {miso_i, rx_sh[BW-1:1]};
    end

    // Operation state, serial clock and shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            is_rx  <= 1'b0;
            tcnt   <= '0;
            snap   <= CFG_RESET;
            tx_sh  <= '0;
            rx_sh  <= '0;
            mosi_q <= 1'b0;
            sclk_q <= CFG_RESET.cpol;
        end else if (accept) begin
            busy   <= 1'b1;
            is_rx  <= start_rx && !start_tx;
            tcnt   <= '0;
            snap   <= cfg_live;
            tx_sh  <= tx_byte;
            rx_sh  <= '0;
            sclk_q <= cfg_live.cpol;
            if (start_tx) begin
                mosi_q <= cfg_live.msb_first ? tx_byte[BW-1] : tx_byte[0];
            end
        end else if (busy) begin
            if (tick) begin
                sclk_q <= ~sclk_q;
                tcnt   <= tcnt + TOG_W'(1);
            end
            if (launch_ev && !is_rx && tcnt != '0 && tcnt != TOG_LAST) begin
                if (snap.msb_first) begin
                    tx_sh  <= tx_sh << 1;
                    mosi_q <= tx_sh[BW-2];
                end else begin
                    tx_sh  <= tx_sh >> 1;
                    mosi_q <= tx_sh[1];
                end
            end
            if (sample_ev && is_rx) begin
                rx_sh <= rx_next;
            end
            if (last) begin
                busy <= 1'b0;
            end
        end else begin
            sclk_q <= cfg_live.cpol;
        end
    end

    // Hand the finished receive byte to the register file
    always_comb begin
        rx_done = last && is_rx;
        rx_byte = sample_ev ? rx_next : rx_sh;
        sclk_o  = sclk_q;
        mosi_o  = mosi_q;
    end
endmodule

// File: rtl/spi_bm_regs.sv
// Module: register file of the byte serial master.
// Decodes host writes, holds configuration, control and data,
// turns start bits into one-cycle pulses and muxes read data.
// Assumes a host data write wins over a receive result in the same cycle.
module spi_bm_regs
    import spi_bm_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              rx_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output spi_cfg_t          cfg,
    output logic              csn,
    output logic              hiz,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              start_tx,
    output logic              start_rx
);
    logic sel_cfg;
    logic sel_ctl;
    logic sel_data;

    // Address decode and command pulses
    always_comb begin
        sel_cfg  = (bus_addr == AW'(OFS_CFG));
        sel_ctl  = (bus_addr == AW'(OFS_CTL));
        sel_data = (bus_addr == AW'(OFS_DATA));
        start_tx = bus_wr && sel_ctl && bus_wdata[CTL_GOWR];
        start_rx = bus_wr && sel_ctl && bus_wdata[CTL_GORD];
    end

    // Register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= CFG_RESET;
            csn     <= 1'b1;
            hiz     <= 1'b1;
            tx_byte <= '0;
        end else begin
            if (bus_wr && sel_cfg) begin
                cfg.msb_first <= bus_wdata[CFG_ORDER];
                cfg.cpol      <= bus_wdata[CFG_CPOL];
                cfg.rx_fall   <= bus_wdata[CFG_RXF];
                cfg.tx_fall   <= bus_wdata[CFG_TXF];
                cfg.presc     <= bus_wdata[PRESC_W-1:0];
            end
            if (bus_wr && sel_ctl) begin
                csn <= bus_wdata[CTL_CSN];
                hiz <= bus_wdata[CTL_HIZ];
            end
            if (bus_wr && sel_data) begin
                tx_byte <= bus_wdata[BYTE_W-1:0];
            end else if (rx_done) begin
                tx_byte <= rx_byte;
            end
        end
    end

    // Read data mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_STAT)) begin
            bus_rdata[0] = busy;
        end else if (sel_cfg) begin
            bus_rdata[CFG_ORDER]     = cfg.msb_first;
            bus_rdata[CFG_CPOL]      = cfg.cpol;
            bus_rdata[CFG_RXF]       = cfg.rx_fall;
            bus_rdata[CFG_TXF]       = cfg.tx_fall;
            bus_rdata[PRESC_W-1:0]   = cfg.presc;
        end else if (sel_ctl) begin
            bus_rdata[CTL_HIZ] = hiz;
            bus_rdata[CTL_CSN] = csn;
        end else if (sel_data) begin
            bus_rdata[BYTE_W-1:0] = tx_byte;
        end
    end
endmodule

// File: rtl/spi_byte_master.sv
// Module: top of the register-mapped byte serial master.
// Joins the register file and the shift engine and drives the pins.
// Assumes a single slave and 8-bit frames only.
module spi_byte_master
    import spi_bm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    output logic              spi_mosi_oe,
    input  logic              spi_miso
);
    spi_cfg_t          cfg;
    logic              csn;
    logic              hiz;
    logic [BYTE_W-1:0] tx_byte;
    logic              start_tx;
    logic              start_rx;
    logic              busy;
    logic              rx_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              sclk_w;
    logic              mosi_w;

    spi_bm_regs #(.AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .cfg       (cfg),
        .csn       (csn),
        .hiz       (hiz),
        .tx_byte   (tx_byte),
        .start_tx  (start_tx),
        .start_rx  (start_rx)
    );

    spi_bm_engine #(.BW(BYTE_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_live (cfg),
        .start_tx (start_tx),
        .start_rx (start_rx),
        .tx_byte  (tx_byte),
        .miso_i   (spi_miso),
        .busy     (busy),
        .sclk_o   (sclk_w),
        .mosi_o   (mosi_w),
        .rx_done  (rx_done),
        .rx_byte  (rx_byte)
    );

    // Pin drivers
    always_comb begin
        spi_sclk    = sclk_w;
        spi_mosi    = mosi_w;
        spi_cs_n    = csn;
        spi_mosi_oe = ~hiz;
    end
endmodule

// File: rtl/spi_bm_chk.sv
// Module: property checker for the byte serial master, bound to the top.
module spi_bm_chk
    import spi_bm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input spi_cfg_t          cfg,
    input logic              busy,
    input logic              sclk,
    input logic              cs_n,
    input logic              mosi_oe
);
    logic ctl_wr;
    logic go_wr;
    always_comb begin
        ctl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
        go_wr  = ctl_wr && (bus_wdata[CTL_GOWR] || bus_wdata[CTL_GORD]);
    end

    // R3
    busy_end_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$stable(sclk));

    // R6
    sclk_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (sclk == $past(cfg.cpol)));

    // R7
    cs_follows_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (cs_n == $past(bus_wdata[CTL_CSN])));

    // R7
    oe_follows_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (mosi_oe == !$past(bus_wdata[CTL_HIZ])));

    // R9
    off_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && !busy && cfg.presc == PRESC_OFF) |=> !busy);

    // R9
    busy_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cfg.presc) != PRESC_OFF));
endmodule

bind spi_byte_master spi_bm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .cfg       (cfg),
    .busy      (busy),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi_oe   (spi_mosi_oe)
);

// File: tb/sim_spi_byte_master.sv
// Bench: scoreboard of transmitted bytes checked by a slave model,
// plus register, timing and pin checks driven from tasks.
module sim_spi_byte_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_mosi_oe;
    logic        spi_miso = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int n_bytes = 0;
    bit finished = 1'b0;

    // operation context owned by the driver
    int       seq = 0;
    bit       op_tx = 1'b1;
    bit       m_msb = 1'b1, m_txf = 1'b1, m_rxf = 1'b0;
    logic [7:0] m_rxb = 8'h00;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    spi_byte_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_mosi_oe(spi_mosi_oe),
        .spi_miso(spi_miso)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] mk_cfg(bit msb, bit cpol, bit rxf, bit txf, int presc);
        mk_cfg = 32'h0;
        mk_cfg[8] = msb; mk_cfg[6] = cpol; mk_cfg[5] = rxf; mk_cfg[4] = txf;
        mk_cfg[2:0] = 3'(presc);
    endfunction

    // Count samples with busy high, starting just after the start write
    task automatic busy_len(output int n);
        n = 0;
        bus_addr = 8'h00;
        #1;
        while (bus_rdata[0] === 1'b1) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic run_tx(bit msb, bit cpol, bit txf, int presc, logic [7:0] b);
        int n;
        bwr(8'h10, mk_cfg(msb, cpol, 1'b0, txf, presc));
        m_msb = msb; m_txf = txf; op_tx = 1'b1;
        exp_q.push_back(b);
        bwr(8'h20, {24'h0, b});
        seq++;
        bwr(8'h14, 32'h4);
        busy_len(n);
        chk("R3 busy length", n, 32'(16 << presc));
        repeat (4) @(negedge clk);
        chk("R6 idle clock", {31'h0, spi_sclk}, {31'h0, cpol});
    endtask

    task automatic run_rx(bit msb, bit cpol, bit rxf, int presc, logic [7:0] b);
        int n;
        logic [31:0] d;
        bwr(8'h10, mk_cfg(msb, cpol, rxf, 1'b0, presc));
        m_msb = msb; m_rxf = rxf; m_rxb = b; op_tx = 1'b0;
        seq++;
        bwr(8'h14, 32'h2);
        busy_len(n);
        chk("R3 busy length", n, 32'(16 << presc));
        brd(8'h20, d);
        chk("R5 received byte", d, {24'h0, b});
    endtask

    // Slave model and scoreboard monitor
    initial begin : slave
        int seen = 0;
        int tg = 0;
        int ncap = 0;
        int ridx = 0;
        logic [7:0] cap = 8'h0;
        logic prev = 1'b1;
        logic fall;
        forever begin
            @(negedge clk);
            if (seq != seen) begin
                seen = seq; tg = 0; ncap = 0; ridx = 0; cap = 8'h0;
                spi_miso = m_msb ? m_rxb[7] : m_rxb[0];
            end else if (spi_sclk !== prev) begin
                tg++;
                fall = (spi_sclk == 1'b0);
                if (op_tx && fall != m_txf && spi_cs_n == 1'b0) begin
                    cap = m_msb ? {cap[6:0], spi_mosi} : {spi_mosi, cap[7:1]};
                    ncap++;
                    if (ncap == 8) begin
                        n_bytes++;
                        ncap = 0;
                        if (exp_q.size() == 0) chk("R4 unexpected byte", {24'h0, cap}, 32'hFFFF_FFFF);
                        else chk("R4 sent byte", {24'h0, cap}, {24'h0, exp_q.pop_front()});
                    end
                end
                if (!op_tx && fall != m_rxf && tg >= 2 && tg <= 15) begin
                    ridx++;
                    spi_miso = m_msb ? m_rxb[7 - ridx] : m_rxb[ridx];
                end
            end
            prev = spi_sclk;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        logic [31:0] d;
        int nb;
        bit moved;
        logic s0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        brd(8'h10, d); chk("R1 cfg reset", d, 32'h153);
        brd(8'h14, d); chk("R1 ctl reset", d, 32'h9);
        brd(8'h00, d); chk("R1 status reset", d, 32'h0);
        brd(8'h20, d); chk("R1 data reset", d, 32'h0);
        chk("R1 pins", {29'h0, spi_cs_n, spi_mosi_oe, spi_sclk}, 32'h5);
        // R7 select and output enable
        bwr(8'h14, 32'h0);
        chk("R7 cs/oe", {30'h0, spi_cs_n, spi_mosi_oe}, 32'h1);
        bwr(8'h14, 32'h9);
        chk("R7 cs/oe", {30'h0, spi_cs_n, spi_mosi_oe}, 32'h2);
        bwr(8'h14, 32'h1);
        chk("R7 cs/oe", {30'h0, spi_cs_n, spi_mosi_oe}, 32'h3);
        // R4 transmit in several formats
        run_tx(1'b1, 1'b1, 1'b1, 3, 8'hA5);
        run_tx(1'b1, 1'b0, 1'b0, 0, 8'h3C);
        run_tx(1'b0, 1'b1, 1'b0, 1, 8'h81);
        run_tx(1'b0, 1'b0, 1'b1, 2, 8'h6E);
        run_tx(1'b1, 1'b0, 1'b1, 6, 8'hD2);
        // R2 start bits read back clear, data register keeps written byte
        brd(8'h14, d); chk("R2 ctl readback", d, 32'h0);
        brd(8'h20, d); chk("R2 data readback", d, 32'hD2);
        // R5 receive in several formats
        run_rx(1'b1, 1'b0, 1'b0, 0, 8'hB4);
        run_rx(1'b0, 1'b1, 1'b0, 1, 8'h1F);
        run_rx(1'b1, 1'b1, 1'b1, 2, 8'hC9);
        run_rx(1'b0, 1'b0, 1'b1, 4, 8'h72);
        // R8 start while busy ignored
        nb = n_bytes;
        bwr(8'h10, mk_cfg(1'b1, 1'b0, 1'b0, 1'b0, 2));
        m_msb = 1'b1; m_txf = 1'b0; op_tx = 1'b1;
        exp_q.push_back(8'h5A);
        bwr(8'h20, 32'h5A);
        seq++;
        bwr(8'h14, 32'h4);
        bwr(8'h20, 32'hC3);
        bwr(8'h14, 32'h4);
        bwr(8'h14, 32'h2);
        brd(8'h00, d); chk("R8 still busy", d, 32'h1);
        repeat (120) @(negedge clk);
        brd(8'h00, d); chk("R8 idle after one byte", d, 32'h0);
        chk("R8 byte count", n_bytes, nb + 1);
        brd(8'h20, d); chk("R8 data untouched", d, 32'hC3);
        // R9 disabled clock
        bwr(8'h10, mk_cfg(1'b1, 1'b0, 1'b0, 1'b0, 7));
        repeat (2) @(negedge clk);
        s0 = spi_sclk;
        moved = 1'b0;
        seq++;
        bwr(8'h14, 32'h4);
        bus_addr = 8'h00;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            #1;
            if (bus_rdata[0] !== 1'b0 || spi_sclk !== s0) moved = 1'b1;
        end
        chk("R9 no activity", {31'h0, moved}, 32'h0);
        chk("R9 idle level", {31'h0, s0}, 32'h0);
        chk("R9 byte count", n_bytes, nb + 1);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule